// File: doc/BRIEF.md
# Debug Interrupt Request Controller

This block gathers the asynchronous requests that ask the core to enter its debug handler and folds them into one pending debug interrupt. There are three sources. The first is an external probe pin, which is synchronized and edge-detected. The second is a break bit that the debug control register writes. The third is a boot request, armed by a hard or soft reset while the boot-mode input is high. The block tells the core that a request is waiting and gives a one-cycle pulse when the request is first raised. It keeps a status bit that says whether the last debug exception the core took was this interrupt. It also drives a wake line, so that a pipeline parked by a wait instruction, or a clock stopped for low power, comes back up.

Requests are ignored while the core reports that it is in debug mode. Any debug exception the core takes, of whatever kind, wipes the pending request, the break bit and the boot request together. A break bit set while in debug mode stays set. It fires on the first cycle after debug mode ends. A probe edge seen during debug mode is lost.

The controller is a four-state machine. BOOT is entered on hard or soft reset. It samples the boot-mode input and always moves to IDLE on the next edge. IDLE waits for a qualified request and moves to SIGNAL. SIGNAL drives the one-cycle take pulse and moves to HOLD, or back to IDLE if a debug exception is taken in that cycle. HOLD keeps the request pending until a debug exception is taken, then returns to IDLE. A soft reset forces BOOT from any state.

Top module: `dbg_intr_ctl`

## Requirements
- R1: While hard reset is asserted, and on the first sampling point after it is released with boot-mode low, dint_pend_o, dint_take_o, wake_o, dint_stat_o and brk_bit_o are all 0.
- R2: A rising edge on probe_int_i, held stable, raises dint_take_o after exactly three rising clock edges (two synchronizer flops plus the edge register). dint_pend_o stays 1 afterwards.
- R3: A probe edge that is detected while debug_mode_i is 1 is dropped. The probe pin then staying high after debug mode ends raises no request, because only edges count.
- R4: Writing brk_wdata_i=1 with brk_wr_i sets brk_bit_o on the next edge and raises dint_take_o one edge after that. The bit stays 1 until a debug exception is taken, which clears it on that edge.
- R5: A request from the break bit or the boot request made while debug_mode_i is 1 does not become pending. It becomes pending on the first edge at which debug_mode_i is 0.
- R6: A pulse on dexc_taken_i clears dint_pend_o, brk_bit_o and the boot request on that edge, whatever kind of debug exception was taken.
- R7: On a dexc_taken_i edge, dint_stat_o takes the value dint_pend_o had just before that edge. It holds its value at all other times.
- R8: After hard reset is released with boot_mode_i=1, dint_take_o is 1 at the second edge. With boot_mode_i=0, no request arises.
- R9: soft_rst_i clears the pending request, brk_bit_o and dint_stat_o on its edge and re-arms the boot request from boot_mode_i. With boot_mode_i=1, dint_take_o rises at the third edge counted from the soft-reset edge.
- R10: wake_o is 1 exactly when dint_pend_o is 1.
- R11: dint_take_o is a one-cycle pulse per pending request. Further requests that arrive while a request is already pending raise no second pulse.
- R12: When brk_wr_i and dexc_taken_i fall on the same edge, the clear wins and brk_bit_o is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset |
| boot_mode_i | input | 1 | Arms the boot request when a reset is applied |
| probe_int_i | input | 1 | Asynchronous interrupt pin from the debug probe |
| brk_wr_i | input | 1 | Write strobe for the break bit |
| brk_wdata_i | input | 1 | Value written to the break bit |
| debug_mode_i | input | 1 | Core is executing in debug mode |
| dexc_taken_i | input | 1 | Core takes a debug exception of any kind this cycle |
| brk_bit_o | output | 1 | Current value of the break bit |
| dint_pend_o | output | 1 | A debug interrupt is pending |
| dint_take_o | output | 1 | One-cycle pulse when a request first becomes pending |
| dint_stat_o | output | 1 | The last debug exception taken was this interrupt |
| wake_o | output | 1 | Restart request for a stalled pipeline or stopped clock |

## Verification
The hardest case to reach is a request that arrives while the core is in debug mode. There are two outcomes to tell apart. A level source must survive and fire once debug mode ends. A probe edge must be lost for good. The bench sweeps every source, with debug mode held high and held low, from a fresh reset. It counts take pulses in a window before debug mode is dropped and in a window after it. It compares both counts with the value worked out for that source.

// File: rtl/dbg_intr_pkg.sv
package dbg_intr_pkg;
    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SIGNAL = 2'd2,
        ST_HOLD   = 2'd3
    } dint_state_e;
endpackage

// File: rtl/dbg_probe_sync.sv
module dbg_probe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise_o = chain_q[LAST] & ~prev_q;

    AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R2
endmodule

// File: rtl/dbg_src_regs.sv
module dbg_src_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic boot_load_i,
    input  logic boot_mode_i,
    input  logic brk_wr_i,
    input  logic brk_wdata_i,
    input  logic dexc_taken_i,
    output logic brk_q_o,
    output logic boot_q_o
);
    logic brk_q;
    logic boot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            brk_q <= 1'b0;
        else if (soft_rst_i)   brk_q <= 1'b0;
        else if (dexc_taken_i) brk_q <= 1'b0;
        else if (brk_wr_i)     brk_q <= brk_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            boot_q <= 1'b0;
        else if (soft_rst_i)   boot_q <= 1'b0;
        else if (boot_load_i)  boot_q <= boot_mode_i;
        else if (dexc_taken_i) boot_q <= 1'b0;
    end

    assign brk_q_o  = brk_q;
    assign boot_q_o = boot_q;

    AST_BRK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (dexc_taken_i && !soft_rst_i) |=> !brk_q_o); // R4
    AST_BOOT_ARMED_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_q_o) |-> $past(boot_load_i)); // R8
endmodule

// File: rtl/dbg_intr_fsm.sv
module dbg_intr_fsm
    import dbg_intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic req_i,
    input  logic debug_mode_i,
    input  logic dexc_taken_i,
    output logic boot_load_o,
    output logic pend_o,
    output logic take_o,
    output logic stat_o
);
    dint_state_e state_q, state_d;
    logic        stat_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_IDLE;
            ST_IDLE:   if (req_i && !debug_mode_i && !dexc_taken_i) state_d = ST_SIGNAL;
            ST_SIGNAL: state_d = dexc_taken_i ? ST_IDLE : ST_HOLD;
            ST_HOLD:   if (dexc_taken_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (soft_rst_i) state_d = ST_BOOT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        boot_load_o = (state_q == ST_BOOT);
        take_o      = (state_q == ST_SIGNAL);
        pend_o      = (state_q == ST_SIGNAL) || (state_q == ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            stat_q <= 1'b0;
        else if (soft_rst_i)   stat_q <= 1'b0;
        else if (dexc_taken_i) stat_q <= pend_o;
    end

    assign stat_o = stat_q;

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R11
    AST_DEBUG_MODE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && debug_mode_i) |=> !take_o); // R3
endmodule

// File: rtl/dbg_intr_ctl.sv
module dbg_intr_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic boot_mode_i,
    input  logic probe_int_i,
    input  logic brk_wr_i,
    input  logic brk_wdata_i,
    input  logic debug_mode_i,
    input  logic dexc_taken_i,
    output logic brk_bit_o,
    output logic dint_pend_o,
    output logic dint_take_o,
    output logic dint_stat_o,
    output logic wake_o
);
    logic probe_rise;
    logic brk_q;
    logic boot_q;
    logic boot_load;
    logic any_req;

    dbg_probe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (probe_int_i),
        .rise_o (probe_rise)
    );

    dbg_src_regs u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst_i),
        .boot_load_i  (boot_load),
        .boot_mode_i  (boot_mode_i),
        .brk_wr_i     (brk_wr_i),
        .brk_wdata_i  (brk_wdata_i),
        .dexc_taken_i (dexc_taken_i),
        .brk_q_o      (brk_q),
        .boot_q_o     (boot_q)
    );

    assign any_req = probe_rise | brk_q | boot_q;

    dbg_intr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst_i),
        .req_i        (any_req),
        .debug_mode_i (debug_mode_i),
        .dexc_taken_i (dexc_taken_i),
        .boot_load_o  (boot_load),
        .pend_o       (dint_pend_o),
        .take_o       (dint_take_o),
        .stat_o       (dint_stat_o)
    );

    assign brk_bit_o = brk_q;
    assign wake_o    = dint_pend_o;

    AST_PEND_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        (dexc_taken_i && !soft_rst_i) |=> !dint_pend_o); // R6
    AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (dexc_taken_i && !soft_rst_i) |=> (dint_stat_o == $past(dint_pend_o))); // R7
endmodule

// File: tb/dbg_intr_ctl_tb.sv
module dbg_intr_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst_i = 1'b0;
    logic boot_mode_i = 1'b0;
    logic probe_int_i = 1'b0;
    logic brk_wr_i = 1'b0;
    logic brk_wdata_i = 1'b0;
    logic debug_mode_i = 1'b0;
    logic dexc_taken_i = 1'b0;
    logic brk_bit_o, dint_pend_o, dint_take_o, dint_stat_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_intr_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .boot_mode_i(boot_mode_i),
        .probe_int_i(probe_int_i), .brk_wr_i(brk_wr_i), .brk_wdata_i(brk_wdata_i),
        .debug_mode_i(debug_mode_i), .dexc_taken_i(dexc_taken_i),
        .brk_bit_o(brk_bit_o), .dint_pend_o(dint_pend_o), .dint_take_o(dint_take_o),
        .dint_stat_o(dint_stat_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic nstep(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hard_reset(input logic bm, input logic dbg);
        @(negedge clk);
        rst_n = 1'b0; boot_mode_i = bm; debug_mode_i = dbg;
        probe_int_i = 1'b0; brk_wr_i = 1'b0; brk_wdata_i = 1'b0;
        dexc_taken_i = 1'b0; soft_rst_i = 1'b0;
        nstep(2);
        rst_n = 1'b1;
    endtask

    task automatic dexc_pulse();
        dexc_taken_i = 1'b1;
        nstep(1);
        dexc_taken_i = 1'b0;
    endtask

    // src: 0 probe, 1 break bit, 2 boot request
    task automatic sweep_one(input int src, input logic dbg);
        int n1;
        int n2;
        int exp1;
        int exp2;
        n1 = 0; n2 = 0;
        hard_reset(src == 2, dbg);
        if (src == 0) probe_int_i = 1'b1;
        if (src == 1) begin brk_wr_i = 1'b1; brk_wdata_i = 1'b1; end
        for (int k = 0; k < 6; k++) begin
            nstep(1);
            brk_wr_i = 1'b0;
            n1 += int'(dint_take_o);
        end
        debug_mode_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            nstep(1);
            n2 += int'(dint_take_o);
        end
        exp1 = dbg ? 0 : 1;
        exp2 = (dbg && src != 0) ? 1 : 0;
        chk(dbg ? "R3/R5 sweep in debug" : "R2/R4/R8 sweep", n1, exp1);
        chk(src == 0 ? "R3 sweep after debug" : "R5 sweep after debug", n2, exp2);
        chk("R10 sweep wake", int'(wake_o), int'(dint_pend_o));
        chk("R6 sweep pend before exc", int'(dint_pend_o), exp1 + exp2);
        dexc_pulse();
        chk("R7 sweep stat", int'(dint_stat_o), exp1 + exp2);
        chk("R6 sweep pend cleared", int'(dint_pend_o), 0);
        chk("R6 sweep brk cleared", int'(brk_bit_o), 0);
        probe_int_i = 1'b0;
        nstep(4);
        chk("R6 sweep no refire", int'(dint_pend_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        nstep(1);
        chk("R1 pend in reset", int'(dint_pend_o), 0);
        chk("R1 take in reset", int'(dint_take_o), 0);
        hard_reset(1'b0, 1'b0);
        nstep(1);
        chk("R1 pend after release", int'(dint_pend_o), 0);
        chk("R1 wake after release", int'(wake_o), 0);
        chk("R1 stat after release", int'(dint_stat_o), 0);
        chk("R1 brk after release", int'(brk_bit_o), 0);
        nstep(4);
        chk("R8 no boot request when low", int'(dint_pend_o), 0);

        // R8 boot timing
        hard_reset(1'b1, 1'b0);
        nstep(1);
        chk("R8 boot take not at edge 1", int'(dint_take_o), 0);
        nstep(1);
        chk("R8 boot take at edge 2", int'(dint_take_o), 1);
        dexc_pulse();

        // R2 probe latency
        hard_reset(1'b0, 1'b0);
        nstep(2);
        probe_int_i = 1'b1;
        nstep(2);
        chk("R2 probe take not at edge 2", int'(dint_take_o), 0);
        nstep(1);
        chk("R2 probe take at edge 3", int'(dint_take_o), 1);
        nstep(1);
        chk("R11 take drops", int'(dint_take_o), 0);
        chk("R2 pend held", int'(dint_pend_o), 1);
        // R11 merge: break bit while pending
        brk_wr_i = 1'b1; brk_wdata_i = 1'b1;
        nstep(1);
        brk_wr_i = 1'b0;
        nstep(3);
        chk("R11 no second take", int'(dint_take_o), 0);
        chk("R4 brk held until exc", int'(brk_bit_o), 1);
        dexc_pulse();
        chk("R4 brk cleared by exc", int'(brk_bit_o), 0);
        nstep(4);
        chk("R3 held probe level no retrigger", int'(dint_pend_o), 0);
        probe_int_i = 1'b0;

        // R4 break bit timing
        nstep(2);
        brk_wr_i = 1'b1; brk_wdata_i = 1'b1;
        nstep(1);
        brk_wr_i = 1'b0;
        chk("R4 brk set", int'(brk_bit_o), 1);
        chk("R4 no take yet", int'(dint_take_o), 0);
        nstep(1);
        chk("R4 take one edge later", int'(dint_take_o), 1);

        // R9 soft reset
        nstep(2);
        boot_mode_i = 1'b1; soft_rst_i = 1'b1;
        nstep(1);
        soft_rst_i = 1'b0;
        chk("R9 pend cleared", int'(dint_pend_o), 0);
        chk("R9 brk cleared", int'(brk_bit_o), 0);
        chk("R9 stat cleared", int'(dint_stat_o), 0);
        nstep(1);
        chk("R9 take not at edge 2", int'(dint_take_o), 0);
        nstep(1);
        chk("R9 take at edge 3", int'(dint_take_o), 1);
        dexc_pulse();
        chk("R7 stat set after interrupt", int'(dint_stat_o), 1);
        nstep(2);
        dexc_pulse();
        chk("R7 stat cleared by other exception", int'(dint_stat_o), 0);

        // R12 write and clear together
        brk_wr_i = 1'b1; brk_wdata_i = 1'b1; dexc_taken_i = 1'b1;
        nstep(1);
        brk_wr_i = 1'b0; dexc_taken_i = 1'b0;
        chk("R12 clear wins", int'(brk_bit_o), 0);
        nstep(3);
        chk("R12 no request", int'(dint_pend_o), 0);

        // near-exhaustive sweep over sources and debug mode
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d < 2; d++) begin
                sweep_one(s, logic'(d));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule